// File: doc/BRIEF.md
# DMA-Aware Interrupt Aggregation Controller

This block collects peripheral and DMA interrupt sources into a single level-sensitive request line for a processor. Software sees two words on a small register bus: a status word that shows which sources are pending, and a mask word that selects which of them may drive the request line.

The source vector is split at a fixed boundary index. Sources below the boundary are level interrupts. Their status bits copy the peripheral inputs on every clock, and software cannot write them. Sources at or above the boundary are DMA events. Each one latches into a sticky status bit that stays set until software writes a zero to that bit position. Every DMA source is assigned by a parameter to one of two classes. An informational event never stops its channel and can latch again as soon as it is cleared. An error event drives a halt output to its DMA channel for as long as its status bit is set.

Top module: `irq_gather_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, status reads 0, mask reads 0, every dma_halt_o bit is 0 and irq_o is 0.
- R2: A write to word address 1 loads the mask register in full, and a later read of address 1 returns the value written. A 1 enables a source and a 0 blocks it.
- R3: Status bits below DMA_BASE (default 16) read back the value that lvl_irq_i had at the previous clock edge. Writes to these bits have no effect.
- R4: A high dma_evt_i[c] at a clock edge sets status bit DMA_BASE+c. The bit stays set after the event input drops.
- R5: A write to word address 0 clears every DMA status bit whose data bit is 0 and leaves unchanged every DMA status bit whose data bit is 1.
- R6: If an event and a clearing write reach the same DMA bit at the same edge, the bit stays set.
- R7: Informational DMA bits are those set in INFO_DMA (default bits 16 and 20 to 23). Their dma_halt_o bit is always 0, and they set again on a new event after being cleared.
- R8: For an error-class DMA bit, dma_halt_o[c] is 1 exactly while status bit DMA_BASE+c is set. Further events while the bit is set keep it set, and the halt output drops in the cycle after the clear.
- R9: irq_o is 1 while any status bit is set whose mask bit is also 1, and it follows status and mask changes within the same cycle.
- R10: A read of word address 0 returns status and a read of address 1 returns mask. Reads of any other address, or with bus_sel_i low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address: 0 status, 1 mask |
| bus_wdata_i | input | N_SRC | Write data |
| bus_rdata_o | output | N_SRC | Read data, combinational from the address |
| lvl_irq_i | input | DMA_BASE | Level interrupt inputs |
| dma_evt_i | input | N_SRC-DMA_BASE | DMA event inputs, sampled at each edge |
| dma_halt_o | output | N_SRC-DMA_BASE | Per-channel stop request |
| irq_o | output | 1 | Combined request to the processor |

## Verification
The assertions assume that dma_evt_i and lvl_irq_i are synchronous to clk_i and that writes happen only when bus_sel_i and bus_wr_i are both high. The bench drives every input on the falling edge and holds each bus write for exactly one rising edge, so each write and each event pulse lands on a single known clock edge. It also puts a clearing write and an event on the same edge on purpose, to exercise R6.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/irq_gather_regif.sv
module irq_gather_regif
  import irq_gather_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  stat_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic              stat_wr_o
);
  logic [N_SRC-1:0] mask_q;
  logic             mask_wr;

  assign stat_wr_o = sel_i && wr_i && (addr_i == REG_STAT);
  assign mask_wr   = sel_i && wr_i && (addr_i == REG_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_wr) mask_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      unique case (addr_i)
        REG_STAT: rdata_o = stat_i;
        REG_MASK: rdata_o = mask_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_gather_dma_bit.sv
module irq_gather_dma_bit #(
  parameter bit IS_INFO = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic stat_o,
  output logic halt_o
);
  logic stat_q;

  // a new event takes priority over a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= evt_i | (stat_q & ~clr_i);
  end

  assign stat_o = stat_q;

  if (IS_INFO) begin : g_info
    assign halt_o = 1'b0;
  end else begin : g_err
    assign halt_o = stat_q;
  end
endmodule

// File: rtl/irq_gather_combine.sv
module irq_gather_combine #(
  parameter int unsigned N_SRC = 32
) (
  input  logic [N_SRC-1:0] stat_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             irq_o
);
  assign irq_o = |(stat_i & mask_i);
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irq_gather_pkg::*;
#(
  parameter int unsigned     N_SRC    = 32,
  parameter int unsigned     DMA_BASE = 16,
  parameter logic [N_SRC-1:0] INFO_DMA = 32'h00F1_0000,
  localparam int unsigned    N_DMA    = N_SRC - DMA_BASE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [N_SRC-1:0]    bus_wdata_i,
  output logic [N_SRC-1:0]    bus_rdata_o,
  input  logic [DMA_BASE-1:0] lvl_irq_i,
  input  logic [N_DMA-1:0]    dma_evt_i,
  output logic [N_DMA-1:0]    dma_halt_o,
  output logic                irq_o
);
  logic [DMA_BASE-1:0] lvl_q;
  logic [N_DMA-1:0]    dma_stat;
  logic [N_SRC-1:0]    stat_q;
  logic [N_SRC-1:0]    mask_q;
  logic                stat_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_irq_i;
  end

  for (genvar c = 0; c < N_DMA; c++) begin : g_dma
    irq_gather_dma_bit #(
      .IS_INFO (INFO_DMA[DMA_BASE+c])
    ) u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (dma_evt_i[c]),
      .clr_i  (stat_wr & ~bus_wdata_i[DMA_BASE+c]),
      .stat_o (dma_stat[c]),
      .halt_o (dma_halt_o[c])
    );
  end

  assign stat_q = {dma_stat, lvl_q};

  irq_gather_regif #(
    .N_SRC (N_SRC)
  ) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (bus_sel_i),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .stat_i    (stat_q),
    .rdata_o   (bus_rdata_o),
    .mask_o    (mask_q),
    .stat_wr_o (stat_wr)
  );

  irq_gather_combine #(
    .N_SRC (N_SRC)
  ) u_comb (
    .stat_i (stat_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/irq_gather_ctrl_chk.sv
module irq_gather_ctrl_chk #(
  parameter int unsigned      N_SRC    = 32,
  parameter int unsigned      DMA_BASE = 16,
  parameter logic [N_SRC-1:0] INFO_DMA = 32'h00F1_0000,
  localparam int unsigned     N_DMA    = N_SRC - DMA_BASE
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [DMA_BASE-1:0] lvl_irq_i,
  input logic [N_DMA-1:0]    dma_evt_i,
  input logic [N_DMA-1:0]    dma_halt_o,
  input logic                irq_o,
  input logic [N_SRC-1:0]    stat_q,
  input logic [N_SRC-1:0]    mask_q,
  input logic                stat_wr
);
  localparam logic [N_DMA-1:0] INFO_CH = INFO_DMA[N_SRC-1:DMA_BASE];

  logic [N_DMA-1:0] dma_s;
  assign dma_s = stat_q[N_SRC-1:DMA_BASE];

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> (stat_q == '0 && mask_q == '0 && !irq_o)); // R1
  AST_LVL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> stat_q[DMA_BASE-1:0] == $past(lvl_irq_i)); // R3
  AST_DMA_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) !stat_wr |=> (dma_s & $past(dma_s)) == $past(dma_s)); // R4
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> (dma_s & $past(dma_evt_i)) == $past(dma_evt_i)); // R6
  AST_INFO_NO_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni) (dma_halt_o & INFO_CH) == '0); // R7
  AST_HALT_NEEDS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni) (dma_halt_o & ~dma_s) == '0); // R8
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> (stat_q != '0 && mask_q != '0)); // R9
endmodule

bind irq_gather_ctrl irq_gather_ctrl_chk #(
  .N_SRC    (N_SRC),
  .DMA_BASE (DMA_BASE),
  .INFO_DMA (INFO_DMA)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lvl_irq_i  (lvl_irq_i),
  .dma_evt_i  (dma_evt_i),
  .dma_halt_o (dma_halt_o),
  .irq_o      (irq_o),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .stat_wr    (stat_wr)
);

// File: tb/irq_gather_ctrl_test.sv
module irq_gather_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] lvl = '0;
  logic [15:0] evt = '0;
  logic [15:0] halt;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_gather_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .lvl_irq_i(lvl), .dma_evt_i(evt), .dma_halt_o(halt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 halt in reset", {16'h0, halt}, 32'h0);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    bus_read(2'd0, d); chk("R1 status", d, 32'h0);
    bus_read(2'd1, d); chk("R1 mask", d, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    bus_write(2'd1, 32'hA5C3_0F01);
    bus_read(2'd1, d); chk("R2 mask readback", d, 32'hA5C3_0F01);
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, d); chk("R2 mask cleared", d, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk); lvl = 16'h8009;
    bus_read(2'd0, d); chk("R3 level mirror", d, 32'h0000_8009);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, d); chk("R3 level write ignored", d, 32'h0000_8009);
    @(negedge clk); lvl = 16'h0;
    bus_read(2'd0, d); chk("R3 level drop", d, 32'h0);
  endtask

  task automatic t_dma_set_clear;
    logic [31:0] d;
    pulse(16'h0300);                       // bits 24, 25
    @(negedge clk);
    bus_read(2'd0, d); chk("R4 sticky set", d, 32'h0300_0000);
    bus_write(2'd0, 32'h0200_0000);        // clear 24, keep 25
    bus_read(2'd0, d); chk("R5 selective clear", d, 32'h0200_0000);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, d); chk("R5 clear all", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    pulse(16'h0002);                       // bit 17
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 32'h0; evt = 16'h0002;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; evt = '0;
    bus_read(2'd0, d); chk("R6 event beats clear", d, 32'h0002_0000);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, d); chk("R6 later clear", d, 32'h0);
  endtask

  task automatic t_info;
    logic [31:0] d;
    pulse(16'h0011);                       // bits 16, 20 informational
    chk("R7 info no halt", {16'h0, halt}, 32'h0);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, d); chk("R7 info cleared", d, 32'h0);
    pulse(16'h0001);
    bus_read(2'd0, d); chk("R7 info relatch", d, 32'h0001_0000);
    chk("R7 info no halt after relatch", {16'h0, halt}, 32'h0);
    bus_write(2'd0, 32'h0);
  endtask

  task automatic t_error;
    logic [31:0] d;
    pulse(16'h0102);                       // bits 17, 24 error class
    chk("R8 halt set", {16'h0, halt}, 32'h0000_0102);
    pulse(16'h0002);
    chk("R8 halt held", {16'h0, halt}, 32'h0000_0102);
    bus_write(2'd0, 32'h0100_0000);        // clear 17 only
    chk("R8 halt released", {16'h0, halt}, 32'h0000_0100);
    bus_write(2'd0, 32'h0);
    chk("R8 all released", {16'h0, halt}, 32'h0);
  endtask

  task automatic t_irq;
    pulse(16'h0004);                       // bit 18
    chk("R9 masked source", {31'h0, irq}, 32'h0);
    bus_write(2'd1, 32'h0004_0000);
    chk("R9 unmasked source", {31'h0, irq}, 32'h1);
    bus_write(2'd0, 32'h0);
    chk("R9 source cleared", {31'h0, irq}, 32'h0);
    bus_write(2'd1, 32'h0000_0008);
    @(negedge clk); lvl = 16'h0008;
    @(negedge clk);
    chk("R9 level source", {31'h0, irq}, 32'h1);
    lvl = 16'h0;
    @(negedge clk);
    chk("R9 level drop", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_addr;
    logic [31:0] d;
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd2, d); chk("R10 unmapped addr", d, 32'h0);
    @(negedge clk); sel = 1'b0; addr = 2'd1;
    #1 chk("R10 no select", rdata, 32'h0);
    bus_read(2'd1, d); chk("R10 mask addr", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mask();
    t_level();
    t_dma_set_clear();
    t_collide();
    t_info();
    t_error();
    t_irq();
    t_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule